// File: doc/BRIEF.md
# Bus Master with Locked Block Transfers

This block sits between a processor's memory-side requesters (the execute stage and a line-fill cache) and a Wishbone bus. It takes one request at a time and turns it into bus beats. Most requests become a single beat. A four-word line refill becomes a block of consecutive reads. A swap becomes a locked pair: a read and then a write to the same address. In both cases the cycle signal stays high from the first beat to the last.

The master also keeps the bus when the requester has its next request ready at the final acknowledge of the current one. That request's first beat starts on the next clock, and the cycle signal does not drop. A stream of writes to a slave that acknowledges at once therefore runs at one write per clock and never gives up ownership. Read data goes back to the requester one beat at a time, each beat marked by a valid pulse. A done pulse closes every request.

Top module: `wbm_master`

## Requirements
- R1: After reset, `wbCyc`, `wbStb`, `rspValid` and `rspDone` are low and `reqReady` is high.
- R2: A single read (`reqKind` = 0) produces exactly one beat with `wbWe` low. In the clock after its acknowledge, `rspValid` and `rspDone` pulse together and `rspData` carries the read word.
- R3: A single write (`reqKind` = 1) produces exactly one beat with `wbWe` high. With an immediate acknowledge it occupies the bus for one clock, and `rspDone` pulses in the clock after the acknowledge.
- R4: A refill (`reqKind` = 2) produces four read beats at the aligned base address and then +4, +8 and +12, with `wbCyc` high throughout. It always uses whole words and ignores `reqByte`. Each beat's data is returned in order with a `rspValid` pulse, and `rspDone` pulses together with the fourth.
- R5: A swap (`reqKind` = 3) produces a read beat and then a write beat to the same address, with `wbCyc` high between them. The read value is returned with `rspValid`, and `rspDone` follows the acknowledge of the write.
- R6: While `wbCyc` is high and `wbAck` is low, `wbStb` stays high and `wbAdr`, `wbWe` and `wbSel` hold their values.
- R7: `wbAdr` is the request address with its two low bits cleared. A word access drives `wbSel` = 4'b1111. A byte access (`reqByte` = 1) drives only lane `addr[1:0]` (bit n of `wbSel`, data bits 8n+7..8n). The byte is copied onto all four lanes of `wbDatO`, and the selected lane of a byte read is returned zero-extended.
- R8: `reqReady` is high in the clock of a request's final acknowledge. A request accepted there starts its first beat in the next clock, and `wbCyc` stays high in between.
- R9: `reqReady` is low while a beat is waiting for its acknowledge. If no request is accepted at the final acknowledge, `wbCyc` and `wbStb` are low in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented |
| reqReady | output | 1 | The presented request is taken at this edge |
| reqKind | input | 2 | 0 single read, 1 single write, 2 four-word refill, 3 swap |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 32 | Write data (low byte used for byte accesses) |
| reqByte | input | 1 | 1 for a byte access, 0 for a word |
| rspValid | output | 1 | One read beat's data is on rspData |
| rspData | output | 32 | Returned read data |
| rspDone | output | 1 | The request has finished |
| wbCyc | output | 1 | Bus cycle |
| wbStb | output | 1 | Bus strobe |
| wbWe | output | 1 | Write enable |
| wbAdr | output | 32 | Word-aligned bus address |
| wbSel | output | 4 | Byte lane selects |
| wbDatO | output | 32 | Write data to the slave |
| wbDatI | input | 32 | Read data from the slave |
| wbAck | input | 1 | Slave acknowledge |

## Verification
The bench runs each request kind twice: once against a slave that acknowledges at once, and once against a slave that inserts random wait states. The zero-wait runs count the clocks with the cycle high and the number of times it rises. That tells a locked block or write stream apart from one that drops the bus or adds an idle clock. The wait-state runs catch a beat whose address or lanes move before its acknowledge. Byte writes followed by byte reads across all four lanes test lane selection and zero-extension. A long seeded random mix of all four kinds, issued back to back at random offsets, is checked beat by beat against a shadow memory kept by the bench.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  typedef enum logic [1:0] {
    KIND_RD   = 2'd0,
    KIND_WR   = 2'd1,
    KIND_FILL = 2'd2,
    KIND_SWAP = 2'd3
  } reqKind_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;   // capture a new request
    logic stepAddr;  // next beat of a refill
    logic toWrite;   // swap turns from read to write
    logic readBeat;  // a read beat is acknowledged
    logic done;      // final acknowledge of a request
  } ctrlStrobes_t;

endpackage

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
  import wbm_pkg::*;
#(
  parameter int FILL_BEATS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  reqKind_t     reqKind,
  input  logic         busAck,
  output logic         busy,
  output logic         reqReady,
  output ctrlStrobes_t strobes
);

  localparam int BEAT_W = (FILL_BEATS > 2) ? $clog2(FILL_BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_FILL = BEAT_W'(FILL_BEATS - 1);

  logic              busyQ;
  reqKind_t          kindQ;
  logic [BEAT_W-1:0] beatQ;

  logic lastBeat;
  logic isWrBeat;
  logic ackNow;
  logic finalAck;
  logic accept;

  always_comb begin
    unique case (kindQ)
      KIND_FILL: lastBeat = (beatQ == LAST_FILL);
      KIND_SWAP: lastBeat = (beatQ != '0);
      default:   lastBeat = 1'b1;
    endcase
    isWrBeat = (kindQ == KIND_WR) || ((kindQ == KIND_SWAP) && (beatQ != '0));
    ackNow   = busyQ & busAck;
    finalAck = ackNow & lastBeat;
    reqReady = !busyQ || finalAck;
    accept   = reqValid & reqReady;

    strobes.loadReq  = accept;
    strobes.stepAddr = ackNow & !lastBeat & (kindQ == KIND_FILL);
    strobes.toWrite  = ackNow & !lastBeat & (kindQ == KIND_SWAP);
    strobes.readBeat = ackNow & !isWrBeat;
    strobes.done     = finalAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      kindQ <= KIND_RD;
      beatQ <= '0;
    end else begin
      busyQ <= accept | (busyQ & !finalAck);
      if (accept) begin
        kindQ <= reqKind;
        beatQ <= '0;
      end else if (ackNow && !lastBeat) begin
        beatQ <= beatQ + 1'b1;
      end
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/wbm_datapath.sv
module wbm_datapath
  import wbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  reqKind_t          reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] busDatI,
  output logic [ADDR_W-1:0] busAdr,
  output logic              busWe,
  output logic [DATA_W/8-1:0] busSel,
  output logic [DATA_W-1:0] busDatO,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  localparam int SEL_W  = DATA_W / 8;
  localparam int LANE_W = (SEL_W > 1) ? $clog2(SEL_W) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SEL_W);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              byteQ;
  logic              weQ;

  logic [LANE_W-1:0] lane;
  logic [SEL_W-1:0]  laneHot;
  logic [DATA_W-1:0] laneShift;

  assign lane = addrQ[LANE_W-1:0];

  for (genvar g = 0; g < SEL_W; g++) begin : g_lane
    assign laneHot[g] = (lane == LANE_W'(g));
  end

  assign busAdr    = {addrQ[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign busWe     = weQ;
  assign busSel    = byteQ ? laneHot : {SEL_W{1'b1}};
  assign busDatO   = byteQ ? {SEL_W{wdataQ[7:0]}} : wdataQ;
  assign laneShift = busDatI >> (8 * lane);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      byteQ  <= 1'b0;
      weQ    <= 1'b0;
    end else if (strobes.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      byteQ  <= reqByte && (reqKind != KIND_FILL);
      weQ    <= (reqKind == KIND_WR);
    end else begin
      if (strobes.stepAddr) addrQ <= addrQ + STEP;
      if (strobes.toWrite)  weQ   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspDone  <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobes.readBeat;
      rspDone  <= strobes.done;
      if (strobes.readBeat) rspData <= byteQ ? DATA_W'(laneShift[7:0]) : busDatI;
    end
  end

endmodule

// File: rtl/wbm_master.sv
module wbm_master
  import wbm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FILL_BEATS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [1:0]          reqKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                reqByte,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspDone,
  output logic                wbCyc,
  output logic                wbStb,
  output logic                wbWe,
  output logic [ADDR_W-1:0]   wbAdr,
  output logic [DATA_W/8-1:0] wbSel,
  output logic [DATA_W-1:0]   wbDatO,
  input  logic [DATA_W-1:0]   wbDatI,
  input  logic                wbAck
);

  reqKind_t     kindIn;
  ctrlStrobes_t ctrlStb;
  logic         busy;

  assign kindIn = reqKind_t'(reqKind);

  wbm_ctrl #(.FILL_BEATS(FILL_BEATS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (kindIn),
    .busAck   (wbAck),
    .busy     (busy),
    .reqReady (reqReady),
    .strobes  (ctrlStb)
  );

  wbm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (ctrlStb),
    .reqKind  (kindIn),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqByte  (reqByte),
    .busDatI  (wbDatI),
    .busAdr   (wbAdr),
    .busWe    (wbWe),
    .busSel   (wbSel),
    .busDatO  (wbDatO),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspDone  (rspDone)
  );

  // strobe stays up across every beat of a locked block
  assign wbCyc = busy;
  assign wbStb = busy;

endmodule

// File: rtl/wbm_master_chk.sv
module wbm_master_chk
  import wbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic                rspValid,
  input logic                rspDone,
  input logic                wbCyc,
  input logic                wbStb,
  input logic                wbWe,
  input logic [ADDR_W-1:0]   wbAdr,
  input logic [DATA_W/8-1:0] wbSel,
  input logic                wbAck,
  input ctrlStrobes_t        ctrlStb
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && !wbAck) |=> (wbStb && $stable(wbAdr) && $stable(wbWe) && $stable(wbSel)));

  assert_swap_turn_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.toWrite |=> (wbCyc && wbWe && $stable(wbAdr)));

  assert_fill_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.stepAddr |=> (wbCyc && !wbWe && (wbAdr == $past(wbAdr) + STEP)));

  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(wbCyc && wbAck && !wbWe));

  assert_done_after_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> $past(wbCyc && wbAck));

  assert_sel_shape_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc |-> (wbSel == '1 || $countones(wbSel) == 1));

  assert_keep_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbAck && reqValid && reqReady) |=> wbCyc);

  assert_no_ready_mid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && !wbAck) |-> !reqReady);

endmodule

bind wbm_master wbm_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspDone  (rspDone),
  .wbCyc    (wbCyc),
  .wbStb    (wbStb),
  .wbWe     (wbWe),
  .wbAdr    (wbAdr),
  .wbSel    (wbSel),
  .wbAck    (wbAck),
  .ctrlStb  (ctrlStb)
);

// File: tb/wbm_master_tb.sv
module wbm_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqByte = 1'b0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspDone;
  logic        wbCyc, wbStb, wbWe;
  logic [31:0] wbAdr;
  logic [3:0]  wbSel;
  logic [31:0] wbDatO;
  logic [31:0] wbDatI;
  logic        wbAck;

  always #4 clk = ~clk;

  wbm_master u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByte(reqByte),
    .rspValid(rspValid), .rspData(rspData), .rspDone(rspDone),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr), .wbSel(wbSel),
    .wbDatO(wbDatO), .wbDatI(wbDatI), .wbAck(wbAck)
  );

  // ---------------- slave model ----------------
  logic [31:0] mem [0:63];
  logic [1:0]  waitLeft;
  logic        waitMode = 1'b0;

  function automatic logic [31:0] initWord(input int i);
    return (32'(i) * 32'h01010101) ^ 32'hA55A0000;
  endfunction

  assign wbAck  = wbCyc && wbStb && (waitLeft == 2'd0);
  assign wbDatI = mem[wbAdr[7:2]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitLeft <= 2'd0;
      for (int i = 0; i < 64; i++) mem[i] <= initWord(i);
    end else if (wbCyc && wbStb) begin
      if (wbAck) begin
        waitLeft <= waitMode ? 2'($urandom_range(2, 0)) : 2'd0;
        if (wbWe)
          for (int l = 0; l < 4; l++)
            if (wbSel[l]) mem[wbAdr[7:2]][l*8 +: 8] <= wbDatO[l*8 +: 8];
      end else begin
        waitLeft <= waitLeft - 2'd1;
      end
    end
  end

  // ---------------- monitor ----------------
  logic [68:0] logBeat [0:1023];
  logic [31:0] logRsp  [0:1023];
  int logCnt = 0, logRspCnt = 0, doneCnt = 0;
  int cycHigh = 0, cycRise = 0, holdViol = 0, readyViol = 0;
  logic        prevWait = 1'b0, prevCyc = 1'b0;
  logic [31:0] prevAdr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (wbCyc && wbStb && wbAck) begin
        logBeat[logCnt] <= {wbAdr, wbWe, wbSel, wbWe ? wbDatO : 32'h0};
        logCnt <= logCnt + 1;
      end
      if (rspValid) begin
        logRsp[logRspCnt] <= rspData;
        logRspCnt <= logRspCnt + 1;
      end
      if (rspDone) doneCnt <= doneCnt + 1;
      if (wbCyc) cycHigh <= cycHigh + 1;
      if (wbCyc && !prevCyc) cycRise <= cycRise + 1;
      if (prevWait && (!wbStb || wbAdr != prevAdr)) holdViol <= holdViol + 1;
      if (wbCyc && !wbAck && reqReady) readyViol <= readyViol + 1;
      prevWait <= wbCyc && !wbAck;
      prevAdr  <= wbAdr;
      prevCyc  <= wbCyc;
    end
  end

  // ---------------- expected model ----------------
  logic [31:0] shadow [0:63];
  logic [68:0] expBeat [0:1023];
  logic [31:0] expRsp  [0:1023];
  int expCnt = 0, expRspCnt = 0, expDone = 0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] laneOf(input logic [31:0] w, input logic [1:0] l);
    return {24'h0, w[l*8 +: 8]};
  endfunction

  task automatic addBeat(input logic [31:0] a, input logic we, input logic [3:0] sel, input logic [31:0] d);
    expBeat[expCnt] = {a, we, sel, we ? d : 32'h0};
    expCnt++;
  endtask

  task automatic shadowWrite(input int idx, input logic [3:0] sel, input logic [31:0] d);
    for (int l = 0; l < 4; l++) if (sel[l]) shadow[idx][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic buildExpected(input logic [1:0] k, input logic [31:0] a, input logic [31:0] wd, input logic b);
    logic [31:0] al;
    logic [3:0]  sel;
    logic [31:0] od;
    int idx;
    al  = {a[31:2], 2'b00};
    idx = int'(a[7:2]);
    sel = b ? (4'b0001 << a[1:0]) : 4'hF;
    od  = b ? {4{wd[7:0]}} : wd;
    case (k)
      2'd0: begin
        addBeat(al, 1'b0, sel, 32'h0);
        expRsp[expRspCnt] = b ? laneOf(shadow[idx], a[1:0]) : shadow[idx]; expRspCnt++;
      end
      2'd1: begin
        addBeat(al, 1'b1, sel, od);
        shadowWrite(idx, sel, od);
      end
      2'd2: begin
        for (int i = 0; i < 4; i++) begin
          addBeat(al + 32'(4 * i), 1'b0, 4'hF, 32'h0);
          expRsp[expRspCnt] = shadow[idx + i]; expRspCnt++;
        end
      end
      default: begin
        addBeat(al, 1'b0, sel, 32'h0);
        addBeat(al, 1'b1, sel, od);
        expRsp[expRspCnt] = b ? laneOf(shadow[idx], a[1:0]) : shadow[idx]; expRspCnt++;
        shadowWrite(idx, sel, od);
      end
    endcase
    expDone++;
  endtask

  // present one request and return at the negedge after it is taken
  task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [31:0] wd, input logic b);
    buildExpected(k, a, wd, b);
    reqKind = k; reqAddr = a; reqWdata = wd; reqByte = b; reqValid = 1'b1;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    reqValid = 1'b0;
    while (doneCnt != expDone || wbCyc) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic compareFrom(input string tag, input int b0, input int r0);
    check(logCnt == expCnt, {tag, " beat count"}, 72'(logCnt), 72'(expCnt));
    for (int i = b0; i < logCnt && i < expCnt; i++)
      check(logBeat[i] == expBeat[i], {tag, " beat"}, 72'(logBeat[i]), 72'(expBeat[i]));
    check(logRspCnt == expRspCnt, {tag, " rsp count"}, 72'(logRspCnt), 72'(expRspCnt));
    for (int i = r0; i < logRspCnt && i < expRspCnt; i++)
      check(logRsp[i] == expRsp[i], {tag, " rsp data"}, 72'(logRsp[i]), 72'(expRsp[i]));
    check(doneCnt == expDone, {tag, " done count"}, 72'(doneCnt), 72'(expDone));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  // ---------------- scenarios ----------------
  initial begin
    int b0, r0, h0, c0;
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd2024);
    for (int i = 0; i < 64; i++) shadow[i] = initWord(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!wbCyc && !wbStb, "R1 bus idle", 72'({wbCyc, wbStb}), 72'(0));
    check(!rspValid && !rspDone, "R1 rsp idle", 72'({rspValid, rspDone}), 72'(0));
    check(reqReady, "R1 ready", 72'(reqReady), 72'(1));

    // R2 single word read, zero wait: one clock of cycle, then release (R9)
    b0 = logCnt; r0 = logRspCnt; h0 = cycHigh; c0 = cycRise;
    issue(2'd0, 32'h0000_0014, 32'h0, 1'b0);
    drain();
    compareFrom("R2 single read", b0, r0);
    check(cycHigh - h0 == 1, "R9 release after read", 72'(cycHigh - h0), 72'(1));

    // R3 single word write, zero wait
    b0 = logCnt; r0 = logRspCnt; h0 = cycHigh;
    issue(2'd1, 32'h0000_0020, 32'hDEAD_BEEF, 1'b0);
    drain();
    compareFrom("R3 single write", b0, r0);
    check(cycHigh - h0 == 1, "R3 one-clock write", 72'(cycHigh - h0), 72'(1));

    // R4 refill, zero wait: four clocks, one cycle rise
    b0 = logCnt; r0 = logRspCnt; h0 = cycHigh; c0 = cycRise;
    issue(2'd2, 32'h0000_0043, 32'h0, 1'b1);
    drain();
    compareFrom("R4 refill", b0, r0);
    check(cycHigh - h0 == 4, "R4 refill clocks", 72'(cycHigh - h0), 72'(4));
    check(cycRise - c0 == 1, "R4 cycle held", 72'(cycRise - c0), 72'(1));

    // R8 back-to-back writes: one per clock, bus never released
    b0 = logCnt; r0 = logRspCnt; h0 = cycHigh; c0 = cycRise;
    for (int i = 0; i < 4; i++) issue(2'd1, 32'h80 + 32'(4 * i), 32'h1111_0000 + 32'(i), 1'b0);
    drain();
    compareFrom("R8 write stream", b0, r0);
    check(cycHigh - h0 == 4, "R8 no idle clock", 72'(cycHigh - h0), 72'(4));
    check(cycRise - c0 == 1, "R8 ownership kept", 72'(cycRise - c0), 72'(1));

    // wait states from here
    waitMode = 1'b1;

    // R5 swap with waits: read then write same address, one cycle rise
    b0 = logCnt; r0 = logRspCnt; c0 = cycRise;
    issue(2'd3, 32'h0000_0030, 32'hCAFE_F00D, 1'b0);
    drain();
    compareFrom("R5 swap", b0, r0);
    check(cycRise - c0 == 1, "R5 locked pair", 72'(cycRise - c0), 72'(1));

    // R7 byte writes to every lane then byte reads and a byte swap
    b0 = logCnt; r0 = logRspCnt;
    for (int l = 0; l < 4; l++) issue(2'd1, 32'h0000_0050 + 32'(l), 32'h0000_00C0 + 32'(l), 1'b1);
    for (int l = 0; l < 4; l++) issue(2'd0, 32'h0000_0050 + 32'(l), 32'h0, 1'b1);
    issue(2'd0, 32'h0000_0050, 32'h0, 1'b0);
    issue(2'd3, 32'h0000_0062, 32'h0000_007E, 1'b1);
    issue(2'd0, 32'h0000_0060, 32'h0, 1'b0);
    drain();
    compareFrom("R7 byte lanes", b0, r0);

    // R6 refill and read under wait states
    b0 = logCnt; r0 = logRspCnt;
    issue(2'd2, 32'h0000_00A0, 32'h0, 1'b0);
    issue(2'd0, 32'h0000_00A8, 32'h0, 1'b0);
    drain();
    compareFrom("R6 waits", b0, r0);

    // random mix, R2 R3 R4 R5 R7 R8
    b0 = logCnt; r0 = logRspCnt;
    for (int n = 0; n < 80; n++) begin
      logic [1:0]  k;
      logic [31:0] a;
      k = 2'($urandom_range(3, 0));
      waitMode = ($urandom_range(1, 0) == 1);
      if (k == 2'd2) a = 32'($urandom_range(60, 0)) * 4 + 32'($urandom_range(3, 0));
      else           a = 32'($urandom_range(255, 0));
      issue(k, a, $urandom(), 1'($urandom_range(1, 0)));
      if ($urandom_range(3, 0) == 0) drain();
    end
    drain();
    compareFrom("R4 R5 random mix", b0, r0);

    check(holdViol == 0, "R6 beat held until ack", 72'(holdViol), 72'(0));
    check(readyViol == 0, "R9 ready low mid-beat", 72'(readyViol), 72'(0));
    finish();
  end

endmodule